// File: doc/BRIEF.md
# Polarity-Selectable Rail Fault Router

This block turns the raw comparator results of four supervised supply rails into two fault flags: one for undervoltage and one for overvoltage. Each rail delivers two bits. The high-tap bit is set when the upper divider tap sits below its threshold. The low-tap bit is set when the lower divider tap sits above its threshold. Every raw bit first passes through a digital glitch filter. The filtered value changes only after the raw level has held for a programmable number of consecutive clocks.

Rails 1 and 2 are always treated as positive supplies. A two-bit polarity select decides whether rails 3 and 4 are positive or negative. On a negative rail the two taps trade roles, so the high-tap bit reports overvoltage and the low-tap bit reports undervoltage. The per-rail conditions are ORed into the two flags, which are registered and passed to a downstream timeout and latch controller. The analog front end is outside this block.

Top module: `rail_fault_router`

## Requirements
- R1: While `rst` is high, and on the first cycle after it falls, both `uv_flag` and `ov_flag` are 0, and every filtered bit is in the no-fault state.
- R2: For rails 1 and 2 under any select value, a filtered high-tap bit of 1 sets `uv_flag`.
- R3: For rails 1 and 2 under any select value, a filtered low-tap bit of 1 sets `ov_flag`.
- R4: With `pol_sel` = 2'b01, rails 3 and 4 are both positive: the high tap maps to UV and the low tap maps to OV.
- R5: With `pol_sel` = 2'b10 or 2'b11, rail 3 is positive and rail 4 is negative.
- R6: With `pol_sel` = 2'b00, rails 3 and 4 are both negative.
- R7: On a negative rail, a filtered high-tap bit of 1 sets `ov_flag` and a filtered low-tap bit of 1 sets `uv_flag`.
- R8: `uv_flag` is the OR of the UV conditions of all four rails, and `ov_flag` is the OR of their OV conditions. UV and OV from different rails can be reported in the same cycle.
- R9: A raw bit that differs from its filtered value for FILTER_LEN consecutive clock edges changes the filtered value at the FILTER_LEN-th edge. The flags then show the change one edge later, FILTER_LEN+1 edges after the first differing sample. A pulse shorter than FILTER_LEN clocks has no effect on the flags.
- R10: Clearing a fault is filtered the same way: a flag returns to 0 only after the raw bit has been back at 0 for FILTER_LEN consecutive clocks.
- R11: `pol_sel` is not filtered. A change of select re-routes the current filtered bits at the next clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| hi_below | input | 4 | Raw high-tap "below threshold" bits, bit i for rail i+1 |
| lo_above | input | 4 | Raw low-tap "above threshold" bits, bit i for rail i+1 |
| pol_sel | input | 2 | Polarity select: 01 high, 10 or 11 open, 00 low |
| uv_flag | output | 1 | Registered undervoltage flag, 1 = fault |
| ov_flag | output | 1 | Registered overvoltage flag, 1 = fault |

## Verification
Two events can land on the same clock edge: a filter finishing its qualification count, and a change of the polarity select. When both happen together, the newly qualified bit must be routed under the new select value. The bench provokes this directly. It holds a rail 4 high-tap bit until exactly the edge where its filter flips, and on that edge moves the select from positive to negative. The flag that rises is judged against a bench model that applies the new select value to the filtered state from before that edge. Random runs with occasional select changes exercise the same collision many more times.

// File: rtl/rfr_pkg.sv
package rfr_pkg;

  // Encoding of the three-level polarity select input.
  typedef enum logic [1:0] {
    POL_BOTH_NEG  = 2'b00,
    POL_BOTH_POS  = 2'b01,
    POL_SPLIT     = 2'b10,
    POL_SPLIT_ALT = 2'b11
  } pol_sel_e;

  // True when the rail at zero-based index idx is treated as negative.
  function automatic logic rail_negative(input pol_sel_e sel, input int idx);
    if (idx == 2)      return (sel == POL_BOTH_NEG);
    else if (idx == 3) return (sel != POL_BOTH_POS);
    else               return 1'b0;
  endfunction

endpackage

// File: rtl/rfr_glitch_filter.sv
module rfr_glitch_filter #(
  parameter int STABLE_CYCLES = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic raw,
  output logic filt
);
  localparam int CNT_W = (STABLE_CYCLES > 1) ? $clog2(STABLE_CYCLES) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(STABLE_CYCLES - 1);

  logic [CNT_W-1:0] run_cnt;

  // Count consecutive edges where the raw level disagrees with the filtered one.
  always_ff @(posedge clk) begin
    if (rst) begin
      filt    <= 1'b0;
      run_cnt <= '0;
    end else if (raw == filt) begin
      run_cnt <= '0;
    end else if (run_cnt == LAST) begin
      filt    <= raw;
      run_cnt <= '0;
    end else begin
      run_cnt <= run_cnt + 1'b1;
    end
  end
endmodule

// File: rtl/rfr_polarity_map.sv
module rfr_polarity_map
  import rfr_pkg::*;
#(
  parameter int RAILS = 4
) (
  input  logic [1:0]       sel,
  input  logic [RAILS-1:0] hi_f,
  input  logic [RAILS-1:0] lo_f,
  output logic [RAILS-1:0] uv_vec,
  output logic [RAILS-1:0] ov_vec
);
  pol_sel_e sel_e;
  assign sel_e = pol_sel_e'(sel);

  for (genvar r = 0; r < RAILS; r++) begin : g_rail
    logic neg;
    assign neg       = rail_negative(sel_e, r);
    // A negative rail swaps the roles of its two taps.
    assign uv_vec[r] = neg ? lo_f[r] : hi_f[r];
    assign ov_vec[r] = neg ? hi_f[r] : lo_f[r];
  end
endmodule

// File: rtl/rail_fault_router.sv
module rail_fault_router #(
  parameter int FILTER_LEN = 8
) (
  input  logic       clk,
  input  logic       rst,
  input  logic [3:0] hi_below,
  input  logic [3:0] lo_above,
  input  logic [1:0] pol_sel,
  output logic       uv_flag,
  output logic       ov_flag
);
  localparam int RAILS = 4;
  localparam int TAPS  = 2 * RAILS;

  logic [TAPS-1:0]  raw_bits;
  logic [TAPS-1:0]  filt_bits;
  logic [RAILS-1:0] uv_vec;
  logic [RAILS-1:0] ov_vec;

  assign raw_bits = {lo_above, hi_below};

  for (genvar t = 0; t < TAPS; t++) begin : g_filt
    rfr_glitch_filter #(.STABLE_CYCLES(FILTER_LEN)) u_filt (
      .clk  (clk),
      .rst  (rst),
      .raw  (raw_bits[t]),
      .filt (filt_bits[t])
    );
  end

  rfr_polarity_map #(.RAILS(RAILS)) u_map (
    .sel    (pol_sel),
    .hi_f   (filt_bits[RAILS-1:0]),
    .lo_f   (filt_bits[TAPS-1:RAILS]),
    .uv_vec (uv_vec),
    .ov_vec (ov_vec)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      uv_flag <= 1'b0;
      ov_flag <= 1'b0;
    end else begin
      uv_flag <= |uv_vec;
      ov_flag <= |ov_vec;
    end
  end
endmodule

// File: rtl/rfr_checker.sv
module rfr_checker #(
  parameter int FILTER_LEN = 8
) (
  input logic       clk,
  input logic       rst,
  input logic [3:0] hi_below,
  input logic [3:0] lo_above,
  input logic [1:0] pol_sel,
  input logic       uv_flag,
  input logic       ov_flag
);
  localparam int SAT = FILTER_LEN + 1;
  localparam int W   = $clog2(SAT + 1) + 1;
  localparam logic [W-1:0] SAT_V = W'(SAT);

  logic [W-1:0] r1_hi_run, r1_lo_run, r4_neg_run, quiet_run;

  function automatic logic [W-1:0] bump(input logic cond, input logic [W-1:0] v);
    if (!cond)          return '0;
    else if (v == SAT_V) return v;
    else                return v + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (rst) begin
      r1_hi_run  <= '0;
      r1_lo_run  <= '0;
      r4_neg_run <= '0;
      quiet_run  <= '0;
    end else begin
      r1_hi_run  <= bump(hi_below[0], r1_hi_run);
      r1_lo_run  <= bump(lo_above[0], r1_lo_run);
      r4_neg_run <= bump(hi_below[3] && (pol_sel == 2'b00), r4_neg_run);
      quiet_run  <= bump((hi_below == 4'b0) && (lo_above == 4'b0), quiet_run);
    end
  end

  AST_RESET_CLEAR: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!uv_flag && !ov_flag)); // R1

  AST_RAIL1_HI_UV: assert property (@(posedge clk) disable iff (rst)
    (r1_hi_run == SAT_V) |-> uv_flag); // R2

  AST_RAIL1_LO_OV: assert property (@(posedge clk) disable iff (rst)
    (r1_lo_run == SAT_V) |-> ov_flag); // R3

  AST_RAIL4_NEG_OV: assert property (@(posedge clk) disable iff (rst)
    (r4_neg_run == SAT_V) |-> ov_flag); // R6

  AST_QUIET_CLEARS: assert property (@(posedge clk) disable iff (rst)
    (quiet_run == SAT_V) |-> (!uv_flag && !ov_flag)); // R10
endmodule

bind rail_fault_router rfr_checker #(.FILTER_LEN(FILTER_LEN)) u_rfr_checker (.*);

// File: tb/rail_fault_router_bench.sv
module rail_fault_router_bench;
  localparam int N = 8;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [3:0] hi_below = '0;
  logic [3:0] lo_above = '0;
  logic [1:0] pol_sel = 2'b01;
  logic       uv_flag, ov_flag;

  int checks = 0;
  int failures = 0;
  int cycles = 0;

  // Model of the requirements
  logic [7:0] m_filt;
  int         m_run [8];
  logic       exp_uv, exp_ov;

  always #10 clk = ~clk;

  rail_fault_router #(.FILTER_LEN(N)) u_rail_fault_router (
    .clk(clk), .rst(rst), .hi_below(hi_below), .lo_above(lo_above),
    .pol_sel(pol_sel), .uv_flag(uv_flag), .ov_flag(ov_flag)
  );

  always @(posedge clk) begin
    cycles++;
    if (cycles > 200000) begin
      failures++;
      $display("FAIL watchdog: run exceeded cycle limit");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  // Rail routing from the polarity requirements R4, R5, R6, R7
  function automatic logic is_neg(input logic [1:0] s, input int r);
    if (r == 2) return (s == 2'b00);
    if (r == 3) return (s != 2'b01);
    return 1'b0;
  endfunction

  function automatic logic [1:0] route(input logic [7:0] f, input logic [1:0] s);
    logic u = 1'b0, o = 1'b0;
    for (int r = 0; r < 4; r++) begin
      if (is_neg(s, r)) begin u |= f[4+r]; o |= f[r]; end
      else              begin u |= f[r];   o |= f[4+r]; end
    end
    return {u, o};
  endfunction

  task automatic model_reset();
    m_filt = '0;
    for (int b = 0; b < 8; b++) m_run[b] = 0;
    exp_uv = 1'b0;
    exp_ov = 1'b0;
  endtask

  task automatic check(input string tag, input logic act, input logic expv, input string what);
    checks++;
    if (act !== expv) begin
      failures++;
      $display("FAIL %s %s: actual=%0b expected=%0b", tag, what, act, expv);
    end
  endtask

  // Drive at negedge, let one edge pass, update model, compare at next negedge.
  task automatic step(input logic [3:0] hi, input logic [3:0] lo, input logic [1:0] s,
                      input string tag);
    logic [7:0] raw;
    logic [1:0] r;
    hi_below = hi;
    lo_above = lo;
    pol_sel  = s;
    @(posedge clk);
    raw = {lo, hi};
    r = route(m_filt, s);
    exp_uv = r[1];
    exp_ov = r[0];
    for (int b = 0; b < 8; b++) begin
      if (raw[b] == m_filt[b]) m_run[b] = 0;
      else if (m_run[b] == N - 1) begin m_filt[b] = raw[b]; m_run[b] = 0; end
      else m_run[b]++;
    end
    @(negedge clk);
    check(tag, uv_flag, exp_uv, "uv_flag");
    check(tag, ov_flag, exp_ov, "ov_flag");
  endtask

  task automatic hold(input int n, input logic [3:0] hi, input logic [3:0] lo,
                      input logic [1:0] s, input string tag);
    for (int i = 0; i < n; i++) step(hi, lo, s, tag);
  endtask

  initial begin
    void'($urandom(32'd4242));
    model_reset();
    repeat (3) @(negedge clk);
    check("R1", uv_flag, 1'b0, "uv_flag in reset");
    check("R1", ov_flag, 1'b0, "ov_flag in reset");
    rst = 1'b0;
    @(negedge clk);
    check("R1", uv_flag, 1'b0, "uv_flag after reset");
    check("R1", ov_flag, 1'b0, "ov_flag after reset");

    // R2: rail 1 high tap -> UV after N+1 edges, and not before
    hold(N, 4'b0001, 4'b0000, 2'b00, "R2");
    check("R9", uv_flag, 1'b0, "uv_flag before N+1 edges");
    step(4'b0001, 4'b0000, 2'b00, "R2");
    check("R2", uv_flag, 1'b1, "uv_flag rail1 hi tap");
    // R10: release needs N clocks
    hold(N - 1, 4'b0000, 4'b0000, 2'b00, "R10");
    check("R10", uv_flag, 1'b1, "uv_flag held during release");
    hold(3, 4'b0000, 4'b0000, 2'b00, "R10");
    check("R10", uv_flag, 1'b0, "uv_flag released");

    // R3: rail 2 low tap -> OV
    hold(N + 2, 4'b0000, 4'b0010, 2'b00, "R3");
    check("R3", ov_flag, 1'b1, "ov_flag rail2 lo tap");
    hold(N + 2, 4'b0000, 4'b0000, 2'b01, "R3");

    // R9: glitch of N-1 clocks never reaches the flags
    hold(N - 1, 4'b0001, 4'b0001, 2'b01, "R9");
    hold(N + 3, 4'b0000, 4'b0000, 2'b01, "R9");
    check("R9", uv_flag, 1'b0, "uv_flag after short glitch");
    check("R9", ov_flag, 1'b0, "ov_flag after short glitch");

    // R4: both positive
    hold(N + 2, 4'b1000, 4'b0100, 2'b01, "R4");
    check("R4", uv_flag, 1'b1, "rail4 hi -> uv");
    check("R4", ov_flag, 1'b1, "rail3 lo -> ov");
    hold(N + 2, 4'b0000, 4'b0000, 2'b01, "R4");

    // R11 collision: rail 4 hi tap qualifies on the same edge select goes negative
    hold(N - 1, 4'b1000, 4'b0000, 2'b01, "R11");
    step(4'b1000, 4'b0000, 2'b00, "R11");
    step(4'b1000, 4'b0000, 2'b00, "R11");
    check("R11", ov_flag, 1'b1, "rail4 rerouted to ov");
    check("R11", uv_flag, 1'b0, "rail4 not uv when negative");
    // R6: both negative, rail 3 low tap -> UV (R7)
    hold(N + 2, 4'b0000, 4'b0100, 2'b00, "R6");
    check("R7", uv_flag, 1'b1, "neg rail3 lo -> uv");
    check("R6", ov_flag, 1'b0, "rail3 lo not ov when negative");

    // R5: open select, rail3 positive, rail4 negative
    hold(N + 2, 4'b1100, 4'b0000, 2'b10, "R5");
    check("R5", uv_flag, 1'b1, "rail3 hi -> uv");
    check("R5", ov_flag, 1'b1, "rail4 hi -> ov");
    step(4'b1100, 4'b0000, 2'b11, "R5");
    check("R5", uv_flag, 1'b1, "sel 11 rail3 hi -> uv");
    check("R5", ov_flag, 1'b1, "sel 11 rail4 hi -> ov");
    hold(N + 2, 4'b0000, 4'b0000, 2'b11, "R5");

    // R8: UV from rail 1 and OV from rail 2 together
    hold(N + 2, 4'b0001, 4'b0010, 2'b01, "R8");
    check("R8", uv_flag, 1'b1, "uv from rail1");
    check("R8", ov_flag, 1'b1, "ov from rail2");
    hold(N + 2, 4'b0000, 4'b0000, 2'b01, "R8");

    // Random with slowly toggling bits and occasional select moves
    begin
      logic [3:0] h = '0, l = '0;
      logic [1:0] s = 2'b01;
      for (int i = 0; i < 4000; i++) begin
        for (int b = 0; b < 4; b++) begin
          if ($urandom_range(0, 11) == 0) h[b] = ~h[b];
          if ($urandom_range(0, 11) == 0) l[b] = ~l[b];
        end
        if ($urandom_range(0, 47) == 0) s = 2'($urandom_range(0, 3));
        step(h, l, s, "RND");
      end
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule